// File: doc/BRIEF.md
# SMBus Register-Read Slave with Packet Error Code

This block is the read side of an SMBus slave. It serves Receive Byte transactions from a register file that lives outside the block. No register address travels in the transaction itself. A local pointer is loaded through a pointer-load strobe when an earlier Send Byte or Write Byte transaction is decoded elsewhere. The pointer keeps its value across transactions, so one register can be polled again and again with bare Receive Byte reads.

SCL and SDA come in as raw levels sampled on the system clock. The block synchronises them and detects edges, start conditions and stop conditions. It drives SDA only through an open-drain enable. After the data byte, the master may acknowledge and keep clocking. In that case the slave shifts out a CRC-8 packet error code computed over the address byte and the data byte. If the master does not acknowledge, the slave lets go of the bus.

Top module: `smb_rdpec_slave`

## Requirements
- R1: The slave pulls SDA low during the ninth SCL pulse only when the first byte after a start equals {DEV_ADDR, 1'b1}. The default DEV_ADDR is 7'h2C, so that byte is 8'h59. A byte with the R/W bit low, or with a different address, gets no acknowledge and no further drive.
- R2: A one-cycle pulse on ptr_ld_i loads ptr_i into the pointer on the next clock edge, and reg_addr_o shows the pointer. The data byte is the value of reg_data_i at reg_addr_o, sent MSB first.
- R3: The pointer holds its value when ptr_ld_i is low, including across complete transactions. Two Receive Byte reads with no load between them return the same register.
- R4: If the master acknowledges the data byte, the next byte the slave sends is a CRC-8 with polynomial 0x07 and initial value 0x00. It is computed MSB first over the address byte and then the data byte.
- R5: If the master does not acknowledge the data byte, the slave drives nothing more, and further clocked bits read as 1.
- R6: After the packet error code byte, the slave releases SDA whatever the master's acknowledge bit is.
- R7: A stop condition releases SDA and returns the slave to idle. A repeated start releases SDA and starts a fresh address phase.
- R8: The open-drain enable changes only while the synchronised SCL is low.
- R9: After reset, sda_oe_o is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw SCL level |
| sda_i | input | 1 | Raw SDA level (wired bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| ptr_ld_i | input | 1 | Load strobe for the register pointer |
| ptr_i | input | PTR_W | New pointer value |
| reg_addr_o | output | PTR_W | Register array read address |
| reg_data_i | input | 8 | Register array read data |

## Verification
A bus edge reaches the state machine three clocks after the pin changes: two synchroniser stages and one edge register. The enable then updates on the following clock, so it settles within four clocks of an SCL fall. The bench holds each bus phase for twelve clocks and reads SDA only at the end of the SCL-high phase, well after that settling time. A pointer load appears on reg_addr_o one clock after the strobe, and the bench sets up every read several bus phases later. The checks for released SDA after a stop are taken one full phase after the SCL fall that would otherwise have shifted out a driven zero.

// File: rtl/smb_rd_pkg.sv
package smb_rd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_DATA, ST_DMACK, ST_PEC, ST_PMACK, ST_HOLD
  } smb_st_e;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/smb_bus_sense.sv
module smb_bus_sense #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_q  <= scl_sh[SYNC-1];
      sda_q  <= sda_sh[SYNC-1];
    end
  end

  assign scl_o      = scl_sh[SYNC-1];
  assign sda_o      = sda_sh[SYNC-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/smb_ptr_reg.sv
module smb_ptr_reg #(
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [PTR_W-1:0] ptr_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_o <= '0;
    else if (ld_i) ptr_o <= ptr_i;
  end
endmodule

// File: rtl/smb_rd_fsm.sv
module smb_rd_fsm
  import smb_rd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] reg_data_i,
  output logic              sda_oe_o,
  output smb_st_e           st_o
);
  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] FULL     = 4'd8;
  localparam logic [7:0] RD_ADDR  = {DEV_ADDR, 1'b1};

  smb_st_e     st;
  logic [3:0]  cnt;
  logic [7:0]  sh;
  logic [7:0]  crc;
  logic        ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      crc   <= '0;
      ack_q <= 1'b0;
    end else if (start_i) begin
      st  <= ST_ADDR;
      cnt <= '0;
      crc <= '0;
    end else if (stop_i) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh  <= {sh[6:0], sda_s_i};
            cnt <= cnt + 4'd1;
          end else if (scl_fall_i && cnt == FULL) begin
            if (sh == RD_ADDR) begin
              st  <= ST_AACK;
              crc <= crc8_step(crc, sh);
            end else begin
              st <= ST_HOLD;
            end
          end
        end
        ST_AACK: if (scl_fall_i) begin
          sh  <= reg_data_i;
          crc <= crc8_step(crc, reg_data_i);
          cnt <= '0;
          st  <= ST_DATA;
        end
        ST_DATA, ST_PEC: if (scl_fall_i) begin
          if (cnt == LAST_BIT) begin
            st <= (st == ST_DATA) ? ST_DMACK : ST_PMACK;
          end else begin
            sh  <= sh << 1;
            cnt <= cnt + 4'd1;
          end
        end
        ST_DMACK: begin
          if (scl_rise_i) ack_q <= ~sda_s_i;
          else if (scl_fall_i) begin
            if (ack_q) begin
              sh  <= crc;
              cnt <= '0;
              st  <= ST_PEC;
            end else begin
              st <= ST_HOLD;
            end
          end
        end
        ST_PMACK: if (scl_fall_i) st <= ST_HOLD;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_AACK:         sda_oe_o = 1'b1;
      ST_DATA, ST_PEC: sda_oe_o = ~sh[7];
      default:         sda_oe_o = 1'b0;
    endcase
  end

  assign st_o = st;
endmodule

// File: rtl/smb_rdpec_slave.sv
module smb_rdpec_slave
  import smb_rd_pkg::*;
#(
  parameter int         PTR_W    = 8,
  parameter int         SYNC     = 2,
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              ptr_ld_i,
  input  logic [PTR_W-1:0]  ptr_i,
  output logic [PTR_W-1:0]  reg_addr_o,
  input  logic [BYTE_W-1:0] reg_data_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  smb_st_e st;

  smb_bus_sense #(.SYNC(SYNC)) u_sense (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk_i, .rst_ni, .ld_i(ptr_ld_i), .ptr_i, .ptr_o(reg_addr_o)
  );

  smb_rd_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni, .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .reg_data_i, .sda_oe_o, .st_o(st)
  );
endmodule

// File: rtl/smb_rdpec_slave_chk.sv
module smb_rdpec_slave_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe_o,
  input logic             ptr_ld_i,
  input logic [PTR_W-1:0] ptr_i,
  input logic [PTR_W-1:0] reg_addr_o
);
  a_r2_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_ld_i |=> reg_addr_o == $past(ptr_i));

  a_r3_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ptr_ld_i |=> $stable(reg_addr_o));

  a_r7_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  a_r7_start_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);

  a_r8_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);
endmodule

bind smb_rdpec_slave smb_rdpec_slave_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i, .rst_ni, .scl_s, .start_det, .stop_det,
  .sda_oe_o, .ptr_ld_i, .ptr_i, .reg_addr_o
);

// File: tb/smb_rdpec_slave_tb.sv
module smb_rdpec_slave_tb;
  localparam int H = 12;
  localparam logic [7:0] RD_BYTE = 8'h59;
  localparam logic [7:0] WR_BYTE = 8'h58;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic ptr_ld = 1'b0;
  logic [7:0] ptr_v = '0;
  logic [7:0] reg_addr, reg_data;
  logic sda_oe;
  logic [7:0] regs [256];
  wire  sda_bus = sda_m & ~sda_oe;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  assign reg_data = regs[reg_addr];

  smb_rdpec_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .ptr_ld_i(ptr_ld), .ptr_i(ptr_v),
    .reg_addr_o(reg_addr), .reg_data_i(reg_data)
  );

  function automatic logic [7:0] sw_crc(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c = crc;
    for (int i = 7; i >= 0; i--) begin
      logic fb = c[7] ^ b[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; tick(H); scl_m = 1'b1; tick(H);
    r = sda_bus; scl_m = 1'b0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
    clk_bit(~mack, r);
  endtask

  task automatic load_ptr(input logic [7:0] p);
    ptr_v = p; ptr_ld = 1'b1; tick(1); ptr_ld = 1'b0; tick(1);
    chk(reg_addr == p, "R2 ptr", reg_addr, p);
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R9 oe", sda_oe, 0);
    chk(reg_addr == 8'h00, "R9 ptr", reg_addr, 0);
  endtask

  task automatic t_read_nack(input logic [7:0] p, input logic [7:0] v);
    logic ack; logic [7:0] d;
    regs[p] = v;
    load_ptr(p);
    bus_start;
    send_byte(RD_BYTE, ack);
    chk(ack, "R1 ack", ack, 1);
    recv_byte(1'b0, d);
    chk(d == v, "R2 data", d, v);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R5 no pec", d, 8'hFF);
    bus_stop;
  endtask

  task automatic t_repeat(input logic [7:0] v);
    logic ack; logic [7:0] d;
    bus_start;
    send_byte(RD_BYTE, ack);
    chk(ack, "R3 ack", ack, 1);
    recv_byte(1'b0, d);
    chk(d == v, "R3 same reg", d, v);
    bus_stop;
  endtask

  task automatic t_pec(input logic [7:0] p, input logic [7:0] v);
    logic ack; logic [7:0] d, pec, exp;
    regs[p] = v;
    load_ptr(p);
    bus_start;
    send_byte(RD_BYTE, ack);
    chk(ack, "R1 ack", ack, 1);
    recv_byte(1'b1, d);
    chk(d == v, "R2 data", d, v);
    recv_byte(1'b1, pec);
    exp = sw_crc(sw_crc(8'h00, RD_BYTE), v);
    chk(pec == exp, "R4 pec", pec, exp);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R6 release", d, 8'hFF);
    bus_stop;
  endtask

  task automatic t_no_match(input logic [7:0] a, input string req);
    logic ack; logic [7:0] d;
    bus_start;
    send_byte(a, ack);
    chk(!ack, req, ack, 0);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, req, d, 8'hFF);
    bus_stop;
  endtask

  task automatic t_stop_mid;
    logic ack;
    regs[8'h33] = 8'hBF;
    load_ptr(8'h33);
    bus_start;
    send_byte(RD_BYTE, ack);
    bus_stop;
    scl_m = 1'b0; tick(H);
    chk(sda_oe == 1'b0, "R7 stop", sda_oe, 0);
    scl_m = 1'b1; tick(H);
  endtask

  task automatic t_rstart;
    logic ack; logic [7:0] d;
    regs[8'h34] = 8'hBF;
    load_ptr(8'h34);
    bus_start;
    send_byte(RD_BYTE, ack);
    bus_start;
    chk(sda_oe == 1'b0, "R7 rstart release", sda_oe, 0);
    send_byte(RD_BYTE, ack);
    chk(ack, "R7 rstart ack", ack, 1);
    recv_byte(1'b0, d);
    chk(d == 8'hBF, "R7 rstart data", d, 8'hBF);
    bus_stop;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) regs[i] = 8'(i * 29) ^ 8'h5A;
    tick(3);
    t_reset;
    rst_n = 1'b1;
    tick(4);
    t_read_nack(8'h12, 8'hA5);
    t_repeat(8'hA5);
    t_pec(8'h40, 8'h3C);
    t_pec(8'h07, 8'h00);
    t_pec(8'hFE, 8'hFF);
    t_no_match(WR_BYTE, "R1 write bit");
    t_no_match(8'h5B, "R1 other addr");
    t_stop_mid;
    t_rstart;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule